// File: doc/BRIEF.md
# Dual Output Port with Signal Substitution

This block drives two 4-bit general-purpose output ports from a small register bank on a 4-bit local bus. Each port has a data register that sets its four pad levels and a control register whose low bit lets the software take the whole port off the pads (high impedance). The block only produces the pad value and output-enable vectors. The analog pad drivers sit outside it.

Three pins of the second port can carry internal signals in place of register data: a clock-frequency output on bit 0, a timer overflow pulse on bit 1 and a buzzer tone on bit 2. The signals themselves come from generators outside the block. A separate 3-bit select input picks plain data or substitution for each of these pins on its own. While a pin is substituted, its data bit acts as a gate: a 0 lets the signal through, and a 1 stops it and parks the pin high. Bit 3 of the second port never carries a substituted signal.

The bus uses a 2-bit offset. Offset 0 is the control register of port 0, offset 1 is the data of port 0, offset 2 is the control register of port 1 and offset 3 is the data of port 1. Writes are strobed, and reads are combinational from the offset.

Top module: `outport_sfx`

## Requirements
- R1: Bit 0 of offset 0 (port 0) and bit 0 of offset 2 (port 1) set high impedance. A 1 drives all four `pad_oe` bits of that port low, and a 0 drives them high.
- R2: Offset 1 holds the port 0 data and offset 3 holds the port 1 data. In plain mode each pad bit (`pad_out[3:0]` for port 0, `pad_out[7:4]` for port 1) equals its register bit, where 1 is high and 0 is low.
- R3: After reset every data and control bit is 0 and all three substitution pins are in plain mode. All pads are therefore driven and low.
- R4: A write updates its register on the rising clock edge at which `bus_wr` is high. The outputs show the new value after that edge, and a cycle without `bus_wr` changes no register.
- R5: A read of offset 0 or 2 returns the control bit in bit 0 and zeros in bits 3:1, whatever was written there. A read of offset 1 or 3 returns the register contents, not the pad level, even while a pin is substituted.
- R6: With substitution on, `pad_out[4]` carries `special_in[0]` (frequency output), `pad_out[5]` carries `special_in[1]` (timer overflow) and `pad_out[6]` carries `special_in[2]` (buzzer). `pad_out[7]` always follows its data bit.
- R7: On a substituted pin, a data bit of 0 passes the signal and a data bit of 1 holds the pin high.
- R8: `sel_special[i]` (1 = substitute, 0 = plain) is sampled on each rising edge, and takes effect after that edge. Each bit acts independently of the other two.
- R9: The high-impedance control of port 1 also turns off the output enables of substituted pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register offset 0..3 |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data for `bus_addr` |
| sel_special | input | 3 | Per-pin substitution select for port 1 bits 2:0 |
| special_in | input | 3 | Substituted signals: bit0 frequency, bit1 timer overflow, bit2 buzzer |
| pad_out | output | 8 | Pad levels, port 0 in 3:0, port 1 in 7:4 |
| pad_oe | output | 8 | Pad output enables, 1 = driven |

## Verification
Two functions can land in the same cycle: a write to the port 1 data register and a change of the substitution select. When both are sampled at one edge, the pin must show the new gate value applied to the new mode, with no mixed state. The bench provokes this by writing offset 3 and flipping `sel_special` in the same driven cycle. A scoreboard entry holds the pad levels expected after the edge, and the monitor compares them. The bench also toggles `special_in` in a cycle where the gate bit is rewritten, and judges the result against the same model.

// File: rtl/outport_pkg.sv
package outport_pkg;
  localparam int unsigned PORT_W = 4;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_DATA = 1'b1
  } reg_kind_e;
endpackage

// File: rtl/outport_rst_sync.sv
module outport_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/outport_regs.sv
module outport_regs
  import outport_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned DATA_W    = PORT_W,
  parameter int unsigned ADDR_W    = $clog2(2 * NUM_PORTS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic [NUM_PORTS-1:0]          hiz_q,
  output logic [NUM_PORTS*DATA_W-1:0]   data_q
);
  localparam int unsigned PIDX_W = ADDR_W - 1;

  logic [NUM_PORTS-1:0]        hiz_d;
  logic [NUM_PORTS*DATA_W-1:0] data_d;
  logic [PIDX_W-1:0]           port_idx;
  reg_kind_e                   kind;

  assign port_idx = addr[ADDR_W-1:1];
  assign kind     = reg_kind_e'(addr[0]);

  always_comb begin
    hiz_d  = hiz_q;
    data_d = data_q;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_idx == PIDX_W'(p)) begin
        if (kind == REG_CTRL) begin
          hiz_d[p] = wdata[0];
        end else begin
          data_d[p*DATA_W +: DATA_W] = wdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiz_q  <= '0;
      data_q <= '0;
    end else if (wr_en) begin
      hiz_q  <= hiz_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    if (kind == REG_CTRL) begin
      rdata = {{(DATA_W-1){1'b0}}, hiz_q[port_idx]};
    end else begin
      rdata = data_q[port_idx*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/outport_pinmux.sv
module outport_pinmux #(
  parameter int unsigned DATA_W   = 4,
  parameter int unsigned NUM_SPEC = 3
) (
  input  logic [DATA_W-1:0]   data,
  input  logic                hiz,
  input  logic [NUM_SPEC-1:0] mode,
  input  logic [NUM_SPEC-1:0] spec,
  output logic [DATA_W-1:0]   pad_o,
  output logic [DATA_W-1:0]   pad_oe
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b < NUM_SPEC) begin : g_spec
      assign pad_o[b] = mode[b] ? (spec[b] | data[b]) : data[b];
    end else begin : g_plain
      assign pad_o[b] = data[b];
    end
  end

  assign pad_oe = {DATA_W{~hiz}};
endmodule

// File: rtl/outport_sfx.sv
module outport_sfx
  import outport_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned DATA_W    = PORT_W,
  parameter int unsigned NUM_SPEC  = 3,
  parameter int unsigned SPEC_PORT = 1,
  parameter int unsigned ADDR_W    = $clog2(2 * NUM_PORTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_SPEC-1:0]         sel_special,
  input  logic [NUM_SPEC-1:0]         special_in,
  output logic [NUM_PORTS*DATA_W-1:0] pad_out,
  output logic [NUM_PORTS*DATA_W-1:0] pad_oe
);
  localparam int unsigned TOTAL_W = NUM_PORTS * DATA_W;

  logic                 rst_sync_n;
  logic [NUM_PORTS-1:0] hiz_q;
  logic [TOTAL_W-1:0]   data_q;
  logic [NUM_SPEC-1:0]  mode_q;
  logic [NUM_SPEC-1:0]  mode_d;

  outport_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  outport_regs #(
    .NUM_PORTS (NUM_PORTS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .hiz_q  (hiz_q),
    .data_q (data_q)
  );

  always_comb begin
    mode_d = sel_special;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= '0;
    end else begin
      mode_q <= mode_d;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [NUM_SPEC-1:0] mode_p;
    logic [NUM_SPEC-1:0] spec_p;

    if (p == SPEC_PORT) begin : g_sub
      assign mode_p = mode_q;
      assign spec_p = special_in;
    end else begin : g_nosub
      assign mode_p = '0;
      assign spec_p = '0;
    end

    outport_pinmux #(
      .DATA_W   (DATA_W),
      .NUM_SPEC (NUM_SPEC)
    ) u_pin (
      .data   (data_q[p*DATA_W +: DATA_W]),
      .hiz    (hiz_q[p]),
      .mode   (mode_p),
      .spec   (spec_p),
      .pad_o  (pad_out[p*DATA_W +: DATA_W]),
      .pad_oe (pad_oe[p*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/outport_sfx_chk.sv
module outport_sfx_chk #(
  parameter int unsigned DATA_W    = 4,
  parameter int unsigned NUM_SPEC  = 3,
  parameter int unsigned SPEC_PORT = 1,
  parameter int unsigned ADDR_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                wd_lsb,
  input logic                wd_msb,
  input logic [DATA_W-1:1]   rd_hi,
  input logic [NUM_SPEC-1:0] special_in,
  input logic [DATA_W-1:0]   port_out,
  input logic [DATA_W-1:0]   port_oe,
  input logic [NUM_SPEC-1:0] gate_bits,
  input logic [NUM_SPEC-1:0] mode_q
);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(2 * SPEC_PORT);
  localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(2 * SPEC_PORT + 1);

  AST_HIZ_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTRL_OFS) |=> (port_oe == {DATA_W{~$past(wd_lsb)}})); // R1

  AST_PLAIN_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DATA_OFS) |=> (port_out[DATA_W-1] == $past(wd_msb))); // R2

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(port_oe)); // R4

  AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr[0] |-> (rd_hi == '0)); // R5

  for (genvar i = 0; i < NUM_SPEC; i++) begin : g_pin
    AST_SUB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i] && !gate_bits[i]) |-> (port_out[i] == special_in[i])); // R6

    AST_SUB_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i] && gate_bits[i]) |-> port_out[i]); // R7
  end
endmodule

bind outport_sfx outport_sfx_chk #(
  .DATA_W    (DATA_W),
  .NUM_SPEC  (NUM_SPEC),
  .SPEC_PORT (SPEC_PORT),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .wd_lsb     (bus_wdata[0]),
  .wd_msb     (bus_wdata[DATA_W-1]),
  .rd_hi      (bus_rdata[DATA_W-1:1]),
  .special_in (special_in),
  .port_out   (pad_out[SPEC_PORT*DATA_W +: DATA_W]),
  .port_oe    (pad_oe[SPEC_PORT*DATA_W +: DATA_W]),
  .gate_bits  (data_q[SPEC_PORT*DATA_W +: NUM_SPEC]),
  .mode_q     (mode_q)
);

// File: tb/test_outport_sfx.sv
module test_outport_sfx;
  logic       clk;
  logic       rst_n;
  logic       bus_wr;
  logic [1:0] bus_addr;
  logic [3:0] bus_wdata;
  logic [3:0] bus_rdata;
  logic [2:0] sel_special;
  logic [2:0] special_in;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic [7:0] out;
    logic [7:0] oe;
    logic [3:0] rd;
    string      req;
  } exp_t;

  exp_t exp_q[$];

  // reference state
  logic       m_hiz0, m_hiz1;
  logic [3:0] m_d0, m_d1;
  logic [2:0] m_mode;

  outport_sfx i_outport_sfx (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .sel_special (sel_special),
    .special_in  (special_in),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic step(input logic wr, input logic [1:0] addr, input logic [3:0] wd,
                      input logic [2:0] sel, input logic [2:0] spec, input string req);
    exp_t e;
    logic [3:0] p1;
    @(negedge clk);
    bus_wr      = wr;
    bus_addr    = addr;
    bus_wdata   = wd;
    sel_special = sel;
    special_in  = spec;
    if (wr) begin
      case (addr)
        2'd0: m_hiz0 = wd[0];
        2'd1: m_d0   = wd;
        2'd2: m_hiz1 = wd[0];
        default: m_d1 = wd;
      endcase
    end
    m_mode = sel;
    for (int b = 0; b < 4; b++) begin
      if (b < 3 && m_mode[b]) p1[b] = spec[b] | m_d1[b];
      else p1[b] = m_d1[b];
    end
    e.out = {p1, m_d0};
    e.oe  = {{4{~m_hiz1}}, {4{~m_hiz0}}};
    case (addr)
      2'd0: e.rd = {3'b000, m_hiz0};
      2'd1: e.rd = m_d0;
      2'd2: e.rd = {3'b000, m_hiz1};
      default: e.rd = m_d1;
    endcase
    e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: pops one expectation per cycle, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if (pad_out !== e.out || pad_oe !== e.oe || bus_rdata !== e.rd) begin
          n_fail++;
          $display("FAIL %s: out=%b oe=%b rd=%b expected out=%b oe=%b rd=%b",
                   e.req, pad_out, pad_oe, bus_rdata, e.out, e.oe, e.rd);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    bus_wr      = 1'b0;
    bus_addr    = 2'd0;
    bus_wdata   = 4'h0;
    sel_special = 3'b000;
    special_in  = 3'b000;
    m_hiz0 = 1'b0; m_hiz1 = 1'b0; m_d0 = 4'h0; m_d1 = 4'h0; m_mode = 3'b000;
    repeat (4) @(negedge clk);
    // R3: reset state seen at the pads
    n_checks++;
    if (pad_out !== 8'h00 || pad_oe !== 8'hFF) begin
      n_fail++;
      $display("FAIL R3: out=%b oe=%b expected out=00000000 oe=11111111", pad_out, pad_oe);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 / R5: register contents after reset
    step(0, 2'd0, 4'h0, 3'b000, 3'b000, "R3");
    step(0, 2'd1, 4'h0, 3'b000, 3'b000, "R3");
    step(0, 2'd2, 4'h0, 3'b000, 3'b000, "R3");
    step(0, 2'd3, 4'h0, 3'b000, 3'b000, "R3");
    // R2 / R4: data writes
    step(1, 2'd1, 4'hA, 3'b000, 3'b000, "R2");
    step(1, 2'd3, 4'h6, 3'b000, 3'b111, "R2");
    step(0, 2'd1, 4'hF, 3'b000, 3'b000, "R4");
    // R1 / R5: high impedance, upper control bits ignored
    step(1, 2'd0, 4'hF, 3'b000, 3'b000, "R1");
    step(0, 2'd0, 4'h0, 3'b000, 3'b000, "R5");
    step(1, 2'd2, 4'h1, 3'b000, 3'b000, "R1");
    step(0, 2'd2, 4'h0, 3'b000, 3'b000, "R5");
    step(1, 2'd2, 4'hE, 3'b000, 3'b000, "R1");
    step(1, 2'd0, 4'h0, 3'b000, 3'b000, "R1");
    // R6 / R7: substitution, gate open
    step(1, 2'd3, 4'h0, 3'b111, 3'b101, "R6");
    step(0, 2'd3, 4'h0, 3'b111, 3'b010, "R6");
    step(0, 2'd3, 4'h0, 3'b111, 3'b111, "R6");
    step(0, 2'd3, 4'h0, 3'b111, 3'b000, "R6");
    // R7 / R5: gate closed, pins high, readback shows register
    step(1, 2'd3, 4'h7, 3'b111, 3'b000, "R7");
    step(0, 2'd3, 4'h0, 3'b111, 3'b000, "R5");
    step(1, 2'd3, 4'h8, 3'b111, 3'b010, "R6");
    // R8: independent selection
    step(0, 2'd1, 4'h0, 3'b010, 3'b111, "R8");
    step(0, 2'd1, 4'h0, 3'b100, 3'b111, "R8");
    step(0, 2'd1, 4'h0, 3'b001, 3'b110, "R8");
    // R4 / R8: write and select change in the same cycle
    step(1, 2'd3, 4'h5, 3'b110, 3'b111, "R8");
    step(1, 2'd3, 4'h2, 3'b011, 3'b001, "R4");
    // R9: hiz over substituted pins
    step(1, 2'd2, 4'h1, 3'b111, 3'b111, "R9");
    step(1, 2'd2, 4'h0, 3'b111, 3'b111, "R9");
    step(0, 2'd3, 4'h0, 3'b000, 3'b111, "R2");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule